// File: doc/BRIEF.md
# Phase-Accumulator Square-Wave Synthesizer

This block makes a square wave whose frequency is set by a programmable tuning word. A phase register of `ACC_W` bits adds the active tuning word on each cycle where the tick enable is high, and it wraps modulo 2^ACC_W. The square-wave output is the top bit of that register. The output frequency is f_tick * word / 2^ACC_W, so a host that wants f_out loads word = 2^ACC_W * f_out / f_tick. Over the long run, frequency and duty are exact. Any single output period may differ from the nominal one by up to one tick, and one period can have a duty as uneven as 1:2.

The host writes a new word with a load strobe. The word is held in a shadow register and moves into the active register on the next tick, so the adder never adds a word that is only partly updated. An odd word makes the phase sequence repeat only after the full 2^ACC_W ticks. An even word repeats sooner and adds spurs to the spectrum, so the block raises a status flag whenever the active word is even.

Top module: `phase_sqwave_synth`

## Requirements
- R1: While `rst_n` is low at a clock edge, the phase register, active word, shadow word and pending flag clear. After that edge `sq_out` is 0 and `even_word` is 1, because an active word of zero is even.
- R2: On each edge where `tick_en` is 1, the phase register becomes (phase + active word) mod 2^ACC_W. `sq_out` always equals bit ACC_W-1 of the phase register.
- R3: On an edge where `tick_en` is 0, the phase does not change and `sq_out` holds. A pending word is not applied on such an edge.
- R4: A load strobe (`word_load`=1) stores `word_in` in the shadow register and marks it pending. On the next edge with `tick_en`=1, the shadow word becomes active. The phase sum at that same edge still uses the old active word, and the new word is first added at the following tick.
- R5: While the active word is zero, ticks leave the phase and `sq_out` unchanged.
- R6: `even_word` equals the inverse of bit 0 of the active word. It changes when a word becomes active, not when the word is loaded.
- R7: Take an odd word below 2^(ACC_W-1) and start the phase at zero. Over the next 2^ACC_W ticks, `sq_out` is high on exactly 2^(ACC_W-1) of them and rises exactly word times.
- R8: Suppose a load strobe and a tick fall on the same edge while an earlier word is pending. The earlier word becomes active, and the newly loaded word stays pending for the next tick.
- R9: `ACC_W` is a parameter and supports at least 16, 20 and 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Update tick; the phase advances on edges where it is high |
| word_in | input | ACC_W | Tuning word to load |
| word_load | input | 1 | Strobe that captures `word_in` into the shadow register |
| sq_out | output | 1 | Square-wave output: top bit of the phase register |
| even_word | output | 1 | High when the active tuning word is even |

## Verification
The hardest behaviour to reach is the whole-period property R7, because it only shows after 2^ACC_W ticks from a phase of exactly zero. The bench therefore instantiates the block with a 16-bit phase register, resets it, loads an odd word and runs one full period while it counts high ticks and rising edges. The other hard case is the timing of the shadow-to-active handover. Random tick gaps, loads that coincide with ticks and back-to-back loads are compared every cycle against a cycle model in the bench.

// File: rtl/sqsynth_pkg.sv
// Package: shared constants and helpers for the square-wave synthesizer.
// Assumes: nothing beyond a legal accumulator width of two bits or more.
package sqsynth_pkg;

    // Default width of the phase register.
    localparam int unsigned DEFAULT_ACC_W = 32;

    // Low-bit test used for the even-word status flag.
    function automatic logic low_bit_clear(input logic lsb);
        return ~lsb;
    endfunction

endpackage

// File: rtl/sqsynth_word_shadow.sv
// Module: holds a loaded tuning word in a shadow register and hands it to
// the active register on the next tick, so the adder sees whole words only.
// Assumes: synchronous active-low reset; load and tick may coincide.
module sqsynth_word_shadow #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             word_load,
    input  logic [ACC_W-1:0] word_in,
    output logic [ACC_W-1:0] active_word
);

    logic [ACC_W-1:0] shadow_q;
    logic             pending_q;

    // Capture loads, then apply a pending word at the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q    <= '0;
            pending_q   <= 1'b0;
            active_word <= '0;
        end else begin
            if (tick_en && pending_q) begin
                active_word <= shadow_q;
            end
            if (word_load) begin
                shadow_q  <= word_in;
                pending_q <= 1'b1;
            end else if (tick_en) begin
                pending_q <= 1'b0;
            end
        end
    end

    // R3: with no tick the active word stays put.
    a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(active_word));

    // R4: a tick with a pending word installs that shadow word.
    a_r4_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && pending_q) |=> active_word == $past(shadow_q));

    // R8: a load at a tick leaves the new word pending.
    a_r8_stays_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && word_load) |=> pending_q);

endmodule

// File: rtl/sqsynth_phase_accum.sv
// Module: modulo-2^ACC_W phase register that adds the active word per tick.
// Assumes: the word input is stable across a tick (supplied by the shadow).
module sqsynth_phase_accum #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase
);

    // Advance the phase by the step on each tick, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick_en) begin
            phase <= phase + step;
        end
    end

    // R3: no tick, no phase movement.
    a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(phase));

    // R5: a zero step leaves the phase unchanged even on a tick.
    a_r5_zero_static: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && step == '0) |=> $stable(phase));

endmodule

// File: rtl/phase_sqwave_synth.sv
// Module: top of the phase-accumulator square-wave synthesizer. The output
// is the phase register's top bit; an optional flag marks even words.
// Assumes: ACC_W >= 2; synchronous active-low reset.
module phase_sqwave_synth
    import sqsynth_pkg::*;
#(
    parameter int unsigned ACC_W         = DEFAULT_ACC_W,
    parameter bit          HAS_EVEN_FLAG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [ACC_W-1:0] word_in,
    input  logic             word_load,
    output logic             sq_out,
    output logic             even_word
);

    localparam int unsigned MSB = ACC_W - 1;

    logic [ACC_W-1:0] active_word;
    logic [ACC_W-1:0] phase;

    sqsynth_word_shadow #(.ACC_W(ACC_W)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .word_load   (word_load),
        .word_in     (word_in),
        .active_word (active_word)
    );

    sqsynth_phase_accum #(.ACC_W(ACC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .step    (active_word),
        .phase   (phase)
    );

    // Output bit is the phase register's top bit.
    assign sq_out = phase[MSB];

    // Even-word flag, present only when the parameter asks for it.
    generate
        if (HAS_EVEN_FLAG) begin : g_even
            assign even_word = low_bit_clear(active_word[0]);
        end else begin : g_no_even
            assign even_word = 1'b0;
        end
    endgenerate

    // R2: a tick advances the phase by the word that was active before it.
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> phase == $past(phase) + $past(active_word));

    // R3: the output holds on cycles without a tick.
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(sq_out));

endmodule

// File: tb/sim_phase_sqwave_synth.sv
`timescale 1ns/1ps
module sim_phase_sqwave_synth;

    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic [W-1:0] word_in = '0;
    logic         word_load = 1'b0;
    logic         sq_out;
    logic         even_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench cycle model state.
    logic [W-1:0] m_phase, m_active, m_shadow;
    logic         m_pend;

    always #4 clk = ~clk;

    phase_sqwave_synth #(.ACC_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .word_in(word_in),
        .word_load(word_load), .sq_out(sq_out), .even_word(even_word)
    );

    function automatic logic exp_out(input logic [W-1:0] p);
        return p[W-1];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, model the edge, stay at next negedge.
    task automatic step(input logic t, input logic ld, input logic [W-1:0] w);
        logic [W-1:0] np, na, ns;
        logic npd;
        tick_en = t; word_load = ld; word_in = w;
        @(posedge clk);
        np = m_phase; na = m_active; ns = m_shadow; npd = m_pend;
        if (!rst_n) begin
            np = '0; na = '0; ns = '0; npd = 1'b0;
        end else begin
            if (t) np = m_phase + m_active;
            if (t && m_pend) na = m_shadow;
            if (ld) begin ns = w; npd = 1'b1; end
            else if (t) npd = 1'b0;
        end
        m_phase = np; m_active = na; m_shadow = ns; m_pend = npd;
        @(negedge clk);
    endtask

    task automatic check_model(input string req);
        check(req, sq_out, exp_out(m_phase));
        check(req, even_word, ~m_active[0]);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int highs, rises;
        logic prev;
        void'($urandom(32'd1234));
        m_phase = 'x; m_active = 'x; m_shadow = 'x; m_pend = 1'bx;
        @(negedge clk);
        // R1: reset clears state.
        rst_n = 1'b0;
        step(1'b1, 1'b1, 16'h1234);
        step(1'b0, 1'b0, '0);
        check("R1 sq_out", sq_out, 1'b0);
        check("R1 even_word", even_word, 1'b1);
        rst_n = 1'b1;

        // R5: zero word, ticks do nothing.
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 1'b0, '0);
            check("R5 zero word static", sq_out, 1'b0);
        end

        // R4/R6: load without tick has no effect on the flag or output.
        step(1'b0, 1'b1, 16'h4001);
        check("R6 flag not changed by load", even_word, 1'b1);
        step(1'b0, 1'b0, '0);
        check("R3 no apply without tick", even_word, 1'b1);
        step(1'b1, 1'b0, '0);   // applies; phase still uses old zero
        check("R4 old word used at handover", sq_out, 1'b0);
        check("R6 odd word active", even_word, 1'b0);
        step(1'b1, 1'b0, '0);   // phase = 0x4001
        check("R4 new word added next tick", sq_out, 1'b0);
        step(1'b1, 1'b0, '0);   // phase = 0x8002
        check("R2 msb rises", sq_out, 1'b1);
        step(1'b0, 1'b0, '0);
        check("R3 held without tick", sq_out, 1'b1);
        check_model("R2 model");

        // R8: load at tick while another word is pending.
        step(1'b0, 1'b1, 16'h0100);
        step(1'b1, 1'b1, 16'h0203);
        check("R8 first word active", even_word, 1'b1);
        step(1'b1, 1'b0, '0);
        check("R8 second word active", even_word, 1'b0);
        check_model("R8 model");

        // R2/R3/R4: random mix against the model.
        for (int i = 0; i < 20000; i++) begin
            logic t, ld;
            logic [W-1:0] w;
            t  = ($urandom % 4) != 0;
            ld = ($urandom % 16) == 0;
            w  = W'($urandom);
            if (($urandom % 8) == 0) w = {W{1'b0}};
            step(t, ld, w);
            check_model("R2 random");
        end

        // R7: full period from zero with an odd word.
        rst_n = 1'b0;
        step(1'b0, 1'b0, '0);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 16'd3);
        step(1'b1, 1'b0, '0);   // apply word, phase stays 0
        highs = 0; rises = 0; prev = sq_out;
        for (int i = 0; i < (1 << W); i++) begin
            step(1'b1, 1'b0, '0);
            if (sq_out) highs++;
            if (sq_out && !prev) rises++;
            prev = sq_out;
        end
        checks++;
        if (highs != (1 << (W-1))) begin
            fails++;
            $display("FAIL R7 high ticks actual=%0d expected=%0d", highs, 1 << (W-1));
        end
        checks++;
        if (rises != 3) begin
            fails++;
            $display("FAIL R7 rises actual=%0d expected=3", rises);
        end
        check_model("R7 model end");

        // R6/R9: even word at the chosen width flags and tracks the model.
        step(1'b0, 1'b1, 16'd6);
        step(1'b1, 1'b0, '0);
        check("R6 even flag R9 width", even_word, 1'b1);
        for (int i = 0; i < 1000; i++) begin
            step(1'b1, 1'b0, '0);
            check_model("R6 even run");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule